// File: doc/BRIEF.md
# Register-Window Inter-Processor Message Queue

This block carries fixed-size messages from one processor to another through two register windows of 32-bit words. The sending side writes the words of a message into a window of data registers. A write to the final data register moves the whole staged message, as one row, into a first-in first-out store. The receiving side reads the head message through the same word indices. A read of the final data register returns that word and retires the message. No separate push or pop strobe exists: writing the closing word commits, and reading the closing word consumes.

The receiving side also has a status word. It reports how many messages are waiting and whether a commit was ever lost because the store was full. A level interrupt stays high while at least one message waits, so the receiver can service the queue by interrupt or by polling the status word.

All accesses are full 32-bit words. Software is expected to move the words of a message in ascending index order, ending with the final index.

Top module: `ipc_msg_queue`

## Requirements
- R1: A message is sixteen 32-bit words at word indices 16 to 31. A write to any index outside 16..31 has no effect on any message.
- R2: A write to index 31 commits the staged words, with the written data as word 31, as one new message at the tail of the queue.
- R3: Staged words not written since the previous commit are delivered as zero. Every commit leaves all staged words at zero.
- R4: A read of index 31 returns word 31 of the head message and removes that message. Messages leave in the order they were committed.
- R5: A read of index 16..30 returns that word of the head message and leaves the queue unchanged.
- R6: A read of index 0 returns the status word: the pending message count in bits 23:12, the sticky overflow flag in bit 0, and zero in all other bits.
- R7: The queue holds up to 128 messages. A commit while 128 are pending is dropped and sets the overflow flag, which stays set until reset.
- R8: A read of index 31 with no message pending returns zero and changes no state.
- R9: The interrupt output is high exactly while the pending count is nonzero. The read that retires the only pending message drops it in the next cycle.
- R10: A read of any index other than 0 and 16..31 returns zero. A read of 16..31 with the queue empty returns zero.
- R11: After reset the count, the overflow flag, the interrupt and the read data are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_wr_en | input | 1 | Sender write strobe, one word per cycle |
| tx_wr_idx | input | 5 | Sender word index |
| tx_wr_data | input | 32 | Sender write data |
| rx_rd_en | input | 1 | Receiver read strobe |
| rx_rd_idx | input | 5 | Receiver word index |
| rx_rd_data | output | 32 | Read data, registered, valid the cycle after the strobe |
| rx_irq | output | 1 | High while a message is pending |

## Verification
On every cycle, the assertions check several behaviours. The count moves by exactly one on a commit or a retire. It never exceeds the depth. A commit to a full store leaves the count at the depth and raises the sticky flag. A retire on an empty queue returns zero and keeps the count at zero. Staged words are zero after each commit. The interrupt falls after the last message is retired.

Other properties involve data across whole messages, and only the bench's scenarios can show them. These are first-in first-out ordering over a full fill and drain, zero-fill of partly written messages, writes outside the window that leave no trace, and non-final reads that leave the head in place.

// File: rtl/ipc_mq_pkg.sv
package ipc_mq_pkg;

   localparam int unsigned DATA_W = 32;

   // zero-extend a message count into a status field
   function automatic logic [DATA_W-1:0] pack_status(input logic [DATA_W-1:0] cnt,
                                                     input int unsigned lsb,
                                                     input int unsigned fw,
                                                     input logic ovf);
      logic [DATA_W-1:0] s;
      s = '0;
      for (int b = 0; b < DATA_W; b++) begin
         if (b >= lsb && b < lsb + fw) s[b] = cnt[b - lsb];
      end
      s[0] = ovf;
      return s;
   endfunction

endpackage

// File: rtl/ipc_mq_stage.sv
module ipc_mq_stage
   import ipc_mq_pkg::*;
#(
   parameter int unsigned MSG_WORDS = 16,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned FIRST_IDX = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DATA_W-1:0]             wr_data,
   output logic                          commit_o,
   output logic [MSG_WORDS*DATA_W-1:0]   row_o
);

   localparam int unsigned LAST_IDX = FIRST_IDX + MSG_WORDS - 1;
   localparam int unsigned HELD     = MSG_WORDS - 1;

   logic [DATA_W-1:0] word_q [HELD];

   assign commit_o = wr_en && (wr_idx == IDX_W'(LAST_IDX));

   for (genvar w = 0; w < HELD; w++) begin : g_word
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(FIRST_IDX + w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        word_q[w] <= '0;
         else if (commit_o) word_q[w] <= '0;
         else if (hit)      word_q[w] <= wr_data;
      end

      assign row_o[w*DATA_W +: DATA_W] = word_q[w];

      AST_STAGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
         commit_o |=> (word_q[w] == '0)); // R3
   end

   // the closing word travels straight into the row
   assign row_o[HELD*DATA_W +: DATA_W] = wr_data;

endmodule

// File: rtl/ipc_mq_store.sv
module ipc_mq_store #(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned ROW_W = 512,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic             pop_i,
   output logic [ROW_W-1:0] head_o,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_o
);

   localparam int unsigned PTR_W = $clog2(DEPTH);

   logic [ROW_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wptr_q, rptr_q;
   logic [CNT_W-1:0] count_q;
   logic             ovf_q;
   logic             full, empty, do_push, do_pop;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full    = (count_q == CNT_W'(DEPTH));
   assign empty   = (count_q == '0);
   assign do_push = push_i && !full;
   assign do_pop  = pop_i && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         if (do_push) wptr_q <= step(wptr_q);
         if (do_pop)  rptr_q <= step(rptr_q);
         case ({do_push, do_pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
         if (push_i && full) ovf_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr_q] <= row_i;
   end

   assign head_o  = mem[rptr_q];
   assign count_o = count_q;
   assign ovf_o   = ovf_q;

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH)); // R7
   AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !full && !pop_i) |=> (count_q == CNT_W'($past(count_q) + 1'b1))); // R2
   AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !empty && !push_i) |=> (count_q == CNT_W'($past(count_q) - 1'b1))); // R4
   AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty && !push_i) |=> (count_q == '0)); // R8
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full && !pop_i) |=> (count_q == CNT_W'(DEPTH) && ovf_q)); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q); // R7

endmodule

// File: rtl/ipc_mq_rdmux.sv
module ipc_mq_rdmux
   import ipc_mq_pkg::*;
#(
   parameter int unsigned MSG_WORDS   = 16,
   parameter int unsigned IDX_W       = 5,
   parameter int unsigned FIRST_IDX   = 16,
   parameter int unsigned STATUS_IDX  = 0,
   parameter int unsigned CNT_LSB     = 12,
   parameter int unsigned CNT_FIELD_W = 12,
   parameter int unsigned CNT_W       = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd_en,
   input  logic [IDX_W-1:0]            rd_idx,
   input  logic [MSG_WORDS*DATA_W-1:0] head_i,
   input  logic [CNT_W-1:0]            count_i,
   input  logic                        ovf_i,
   output logic                        pop_o,
   output logic [DATA_W-1:0]           rd_data_o
);

   localparam int unsigned LAST_IDX = FIRST_IDX + MSG_WORDS - 1;

   logic [DATA_W-1:0] sel;
   logic              in_win;

   assign pop_o = rd_en && (rd_idx == IDX_W'(LAST_IDX));

   always_comb begin
      sel    = '0;
      in_win = 1'b0;
      for (int w = 0; w < int'(MSG_WORDS); w++) begin
         if (rd_idx == IDX_W'(FIRST_IDX + w)) begin
            in_win = 1'b1;
            sel    = head_i[w*DATA_W +: DATA_W];
         end
      end
      if (rd_idx == IDX_W'(STATUS_IDX))
         sel = pack_status(DATA_W'(count_i), CNT_LSB, CNT_FIELD_W, ovf_i);
      else if (!in_win || count_i == '0)
         sel = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data_o <= '0;
      else if (rd_en) rd_data_o <= sel;
   end

   AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_o && count_i == '0) |=> (rd_data_o == '0)); // R8
   AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_idx != IDX_W'(STATUS_IDX) &&
       (rd_idx < IDX_W'(FIRST_IDX) || rd_idx > IDX_W'(LAST_IDX))) |=> (rd_data_o == '0)); // R10

endmodule

// File: rtl/ipc_msg_queue.sv
module ipc_msg_queue
   import ipc_mq_pkg::*;
#(
   parameter int unsigned MSG_WORDS   = 16,
   parameter int unsigned IDX_W       = 5,
   parameter int unsigned FIRST_IDX   = 16,
   parameter int unsigned DEPTH       = 128,
   parameter int unsigned STATUS_IDX  = 0,
   parameter int unsigned CNT_LSB     = 12,
   parameter int unsigned CNT_FIELD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_wr_en,
   input  logic [IDX_W-1:0]  tx_wr_idx,
   input  logic [31:0]       tx_wr_data,
   input  logic              rx_rd_en,
   input  logic [IDX_W-1:0]  rx_rd_idx,
   output logic [31:0]       rx_rd_data,
   output logic              rx_irq
);

   localparam int unsigned ROW_W    = MSG_WORDS * DATA_W;
   localparam int unsigned CNT_W    = $clog2(DEPTH + 1);
   localparam int unsigned LAST_IDX = FIRST_IDX + MSG_WORDS - 1;

   if (MSG_WORDS < 2) begin : g_bad_words
      $error("message needs at least two words");
   end
   if (LAST_IDX >= (1 << IDX_W)) begin : g_bad_window
      $error("data window exceeds index space");
   end
   if (STATUS_IDX >= FIRST_IDX && STATUS_IDX <= LAST_IDX) begin : g_bad_status
      $error("status index overlaps data window");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("depth must be at least two");
   end
   if (CNT_W > CNT_FIELD_W || CNT_LSB + CNT_FIELD_W > DATA_W || CNT_LSB == 0) begin : g_bad_field
      $error("count field does not fit the status word");
   end

   logic             commit;
   logic [ROW_W-1:0] stage_row, head_row;
   logic             pop;
   logic [CNT_W-1:0] count;
   logic             ovf;

   ipc_mq_stage #(
      .MSG_WORDS (MSG_WORDS),
      .IDX_W     (IDX_W),
      .FIRST_IDX (FIRST_IDX)
   ) i_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tx_wr_en),
      .wr_idx   (tx_wr_idx),
      .wr_data  (tx_wr_data),
      .commit_o (commit),
      .row_o    (stage_row)
   );

   ipc_mq_store #(
      .DEPTH (DEPTH),
      .ROW_W (ROW_W),
      .CNT_W (CNT_W)
   ) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (commit),
      .row_i   (stage_row),
      .pop_i   (pop),
      .head_o  (head_row),
      .count_o (count),
      .ovf_o   (ovf)
   );

   ipc_mq_rdmux #(
      .MSG_WORDS   (MSG_WORDS),
      .IDX_W       (IDX_W),
      .FIRST_IDX   (FIRST_IDX),
      .STATUS_IDX  (STATUS_IDX),
      .CNT_LSB     (CNT_LSB),
      .CNT_FIELD_W (CNT_FIELD_W),
      .CNT_W       (CNT_W)
   ) i_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rx_rd_en),
      .rd_idx    (rx_rd_idx),
      .head_i    (head_row),
      .count_i   (count),
      .ovf_i     (ovf),
      .pop_o     (pop),
      .rd_data_o (rx_rd_data)
   );

   assign rx_irq = (count != '0);

   AST_IRQ_LAST_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count == CNT_W'(1) && !commit) |=> !rx_irq); // R9
   AST_IRQ_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !pop) |=> rx_irq); // R9

endmodule

// File: tb/test_ipc_msg_queue.sv
module test_ipc_msg_queue;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_wr_en = 1'b0;
   logic [4:0]  tx_wr_idx = '0;
   logic [31:0] tx_wr_data = '0;
   logic        rx_rd_en = 1'b0;
   logic [4:0]  rx_rd_idx = '0;
   logic [31:0] rx_rd_data;
   logic        rx_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ipc_msg_queue i_ipc_msg_queue (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_wr_en   (tx_wr_en),
      .tx_wr_idx  (tx_wr_idx),
      .tx_wr_data (tx_wr_data),
      .rx_rd_en   (rx_rd_en),
      .rx_rd_idx  (rx_rd_idx),
      .rx_rd_data (rx_rd_data),
      .rx_irq     (rx_irq)
   );

   function automatic logic [31:0] pat(input int m, input int w);
      return 32'hC000_0000 | 32'(m << 12) | 32'(w << 4) | 32'h5;
   endfunction

   function automatic logic [31:0] status_of(input int cnt, input bit ovf);
      return (32'(cnt) << 12) | 32'(ovf);
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      @(negedge clk);
      tx_wr_en   = 1'b1;
      tx_wr_idx  = 5'(idx);
      tx_wr_data = d;
      @(negedge clk);
      tx_wr_en   = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [31:0] d);
      @(negedge clk);
      rx_rd_en  = 1'b1;
      rx_rd_idx = 5'(idx);
      @(negedge clk);
      rx_rd_en  = 1'b0;
      d = rx_rd_data;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      check(rx_rd_data, 32'h0, "R11 rd_data");
      check(32'(rx_irq), 32'h0, "R11 irq");
      rd(0, v); check(v, status_of(0, 0), "R11 status");

      // R8 retire on empty queue
      rd(31, v); check(v, 32'h0, "R8 empty pop data");
      rd(0, v);  check(v, status_of(0, 0), "R8 empty pop count");
      rd(20, v); check(v, 32'h0, "R10 empty window read");

      // R2 full message, R5 non-final reads, R4 retire, R9 irq
      for (int w = 0; w < 16; w++) wr(16 + w, pat(900, w));
      check(32'(rx_irq), 32'h1, "R9 irq after commit");
      rd(0, v); check(v, status_of(1, 0), "R6 count one");
      for (int w = 0; w < 15; w++) begin
         rd(16 + w, v); check(v, pat(900, w), "R5 head word");
      end
      rd(0, v); check(v, status_of(1, 0), "R5 no pop");
      rd(31, v); check(v, pat(900, 15), "R4 last word");
      check(32'(rx_irq), 32'h0, "R9 irq after last retire");
      rd(0, v); check(v, status_of(0, 0), "R4 count back to zero");

      // R3 partial message, R1 out-of-window writes ignored
      wr(17, 32'h1111_2222);
      wr(5, 32'hDEAD_0005);
      wr(0, 32'hDEAD_0000);
      wr(31, 32'h3333_4444);
      rd(16, v); check(v, 32'h0, "R3 unwritten word 16");
      rd(17, v); check(v, 32'h1111_2222, "R3 written word 17");
      for (int w = 18; w < 31; w++) begin
         rd(w, v); check(v, 32'h0, "R3 unwritten word");
      end
      rd(5, v);  check(v, 32'h0, "R10 hole read");
      rd(12, v); check(v, 32'h0, "R10 hole read");
      rd(0, v);  check(v, status_of(1, 0), "R1 stray writes no effect");
      rd(31, v); check(v, 32'h3333_4444, "R3 last word");
      // R3 staging cleared by commit
      wr(31, 32'h5555_6666);
      for (int w = 16; w < 31; w++) begin
         rd(w, v); check(v, 32'h0, "R3 stage cleared");
      end
      rd(31, v); check(v, 32'h5555_6666, "R3 last after clear");

      // R7 fill to depth, overflow, drain in order
      for (int m = 0; m < 128; m++) begin
         for (int w = 0; w < 16; w++) wr(16 + w, pat(m, w));
         rd(0, v); check(v, status_of(m + 1, 0), "R7 fill count");
      end
      for (int w = 0; w < 16; w++) wr(16 + w, pat(999, w));
      rd(0, v); check(v, status_of(128, 1), "R7 overflow drop");
      for (int m = 0; m < 128; m++) begin
         for (int w = 0; w < 16; w++) begin
            rd(16 + w, v); check(v, pat(m, w), "R4 fifo order");
         end
         check(32'(rx_irq), 32'(m != 127), "R9 irq while draining");
      end
      rd(0, v);  check(v, status_of(0, 1), "R7 overflow sticky");
      rd(31, v); check(v, 32'h0, "R8 empty after drain");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule